// File: doc/BRIEF.md
# Parallel NOR Flash Command Interface Emulator

This block models the command front end of a byte-wide parallel NOR flash on top of a small on-chip byte array. A host issues bus writes of address and data. Most commands begin with a two-write unlock prefix. From these writes the block decodes commands that reset to reading, enter identification mode, enter query mode, program a byte, enter a fast-program mode without unlock cycles, erase one block, erase the whole array, and suspend or resume a block erase.

Reads return one of four things. They return array contents in normal reading, identification codes in identification mode, and query words in query mode. While an operation runs or has failed, they return a status byte. Program and erase time is replaced by a busy countdown whose length is set by a parameter. A ready output stays low for the whole countdown. The block can stand in for a flash device in a subsystem test, or act as a software-visible flash model inside a larger chip.

Top module: `norcmd_emu`

## Requirements
- R1: After reset every array byte reads FFh, `rdy` is 1 and the block is in reading mode.
- R2: The writes AAh@AAAh, 55h@555h, A0h@AAAh, then data@address store (old AND data) at that address, so a program can only clear bits.
- R3: If a program tries to change any 0 bit to 1, that bit stays 0. From that program on, every read returns status bit 5 (DQ5) = 1, bit 7 = complement of bit 7 of the written data, bits 4..0 = 0. This lasts until a write of F0h to any address.
- R4: A write that does not match the expected data and address of an unlock or erase-prefix cycle returns the decoder to reading mode, and the sequence has no effect.
- R5: Third cycle 90h@AAAh enters identification mode. Reads with low address byte 00h return 20h, 02h returns the `DEV_CODE` parameter, any other value returns 00h. F0h returns to reading.
- R6: A single write of 98h@0AAh from reading or identification mode enters query mode. Low address bytes 20h/22h/24h read 51h/52h/59h, others 00h. The write is ignored in fast-program mode.
- R7: While a program runs, reads return bit 7 = complement of written bit 7 and bits 4..0 = 0. Bit 6 inverts on every status read (busy or error). It does not change on array, identification or query reads.
- R8: `rdy` goes low on the clock edge that accepts the final command write. It stays low for exactly `PROG_CLKS` cycles for a program and exactly `ERASE_CLKS` cycles for an erase.
- R9: Third cycle 20h@AAAh enters fast-program mode. In this mode A0h then data@address programs without unlock cycles, and the block returns to this mode after the program. 90h followed by 00h leaves it.
- R10: The writes AAh@AAAh, 55h@555h, 80h@AAAh, AAh@AAAh, 55h@555h, then 30h@any address in a block set that block to FFh. During the erase, status reads have bit 7 = 0 and bit 5 = 0.
- R11: The same erase prefix followed by 10h@AAAh sets every byte of the array to FFh.
- R12: B0h written during a block erase pauses the countdown and sets `rdy` to 1. Reads inside the erasing block then return bit 7 = 1 with bit 6 held. Reads elsewhere return array data. 30h resumes the erase.
- R13: `rd_vld` is 1 exactly one cycle after each `rd_en` cycle, with `rdata` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| rd_en | input | 1 | Bus read strobe, one cycle per read |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | 8 | Write data / command byte |
| rdata | output | 8 | Read result, registered |
| rd_vld | output | 1 | Marks the cycle in which rdata holds a read result |
| rdy | output | 1 | Ready (1) or busy (0) |

## Verification
The bench sets `PROG_CLKS` to 6 and `ERASE_CLKS` to 12 and keeps a 64-byte array with 16-byte blocks. The short countdowns make it practical to count every busy cycle exactly. They still leave room for two status reads inside a program, and for a suspend write inside a block erase. With four blocks, one block can be erased while a neighbouring block holds data that must survive both the suspend and the resumed erase.

// File: rtl/norcmd_pkg.sv
// Shared types and command constants for the NOR command interface emulator.
// Assumes a byte-wide bus; unlock addresses are byte addresses.
package norcmd_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_READ, ST_UNL1, ST_UNL2, ST_AUTO, ST_CFI, ST_PGM,
        ST_ER1, ST_ER2, ST_ER3, ST_BYP, ST_BYP_PGM, ST_BYP_EXIT,
        ST_BUSY_P, ST_BUSY_E, ST_SUSP, ST_ERR
    } cmd_state_e;

    typedef enum logic [1:0] {
        OP_NONE, OP_PROG, OP_BLK_ERASE, OP_CHIP_ERASE
    } op_kind_e;

    localparam logic [7:0] C_KEY1    = 8'hAA;
    localparam logic [7:0] C_KEY2    = 8'h55;
    localparam logic [7:0] C_IDENT   = 8'h90;
    localparam logic [7:0] C_PROG    = 8'hA0;
    localparam logic [7:0] C_FASTPGM = 8'h20;
    localparam logic [7:0] C_ERSETUP = 8'h80;
    localparam logic [7:0] C_CHIP    = 8'h10;
    localparam logic [7:0] C_BLOCK   = 8'h30;
    localparam logic [7:0] C_PAUSE   = 8'hB0;
    localparam logic [7:0] C_RESET   = 8'hF0;
    localparam logic [7:0] C_QUERY   = 8'h98;
    localparam logic [7:0] C_LEAVE   = 8'h00;

    localparam logic [11:0] A_KEY1  = 12'hAAA;
    localparam logic [11:0] A_KEY2  = 12'h555;
    localparam logic [11:0] A_QUERY = 12'h0AA;

endpackage

// File: rtl/norcmd_decoder.sv
// Command decoder and mode state machine.
// Assumes at most one bus write per cycle; launches operations through op_go.
module norcmd_decoder
    import norcmd_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              op_done,
    input  logic              prog_fail,
    output cmd_state_e        st,
    output logic              op_go,
    output op_kind_e          op_kind,
    output logic              pause
);
    logic hit_k1, hit_k2, hit_q;
    logic byp_q, byp_d, blk_q;
    cmd_state_e nxt;

    assign hit_k1 = (addr == ADDR_W'(A_KEY1));
    assign hit_k2 = (addr == ADDR_W'(A_KEY2));
    assign hit_q  = (addr == ADDR_W'(A_QUERY));
    assign pause  = (st == ST_SUSP);

    // Next-state decode for each bus write and operation completion.
    always_comb begin
        nxt     = st;
        op_go   = 1'b0;
        op_kind = OP_NONE;
        byp_d   = byp_q;
        case (st)
            ST_READ: if (wr_en) begin
                if (wdata == C_KEY1 && hit_k1)      nxt = ST_UNL1;
                else if (wdata == C_QUERY && hit_q) nxt = ST_CFI;
            end
            ST_UNL1: if (wr_en) nxt = (wdata == C_KEY2 && hit_k2) ? ST_UNL2 : ST_READ;
            ST_UNL2: if (wr_en) begin
                nxt = ST_READ;
                if (hit_k1) begin
                    case (wdata)
                        C_IDENT:   nxt = ST_AUTO;
                        C_PROG:    nxt = ST_PGM;
                        C_FASTPGM: nxt = ST_BYP;
                        C_ERSETUP: nxt = ST_ER1;
                        default:   nxt = ST_READ;
                    endcase
                end
            end
            ST_AUTO: if (wr_en) begin
                if (wdata == C_RESET)               nxt = ST_READ;
                else if (wdata == C_QUERY && hit_q) nxt = ST_CFI;
            end
            ST_CFI: if (wr_en && wdata == C_RESET) nxt = ST_READ;
            ST_PGM: if (wr_en) begin
                op_go   = 1'b1;
                op_kind = OP_PROG;
                byp_d   = 1'b0;
                nxt     = ST_BUSY_P;
            end
            ST_ER1: if (wr_en) nxt = (wdata == C_KEY1 && hit_k1) ? ST_ER2 : ST_READ;
            ST_ER2: if (wr_en) nxt = (wdata == C_KEY2 && hit_k2) ? ST_ER3 : ST_READ;
            ST_ER3: if (wr_en) begin
                if (wdata == C_CHIP && hit_k1) begin
                    op_go = 1'b1; op_kind = OP_CHIP_ERASE; nxt = ST_BUSY_E;
                end else if (wdata == C_BLOCK) begin
                    op_go = 1'b1; op_kind = OP_BLK_ERASE; nxt = ST_BUSY_E;
                end else begin
                    nxt = ST_READ;
                end
            end
            ST_BYP: if (wr_en) begin
                if (wdata == C_PROG)       nxt = ST_BYP_PGM;
                else if (wdata == C_IDENT) nxt = ST_BYP_EXIT;
            end
            ST_BYP_PGM: if (wr_en) begin
                op_go   = 1'b1;
                op_kind = OP_PROG;
                byp_d   = 1'b1;
                nxt     = ST_BUSY_P;
            end
            ST_BYP_EXIT: if (wr_en) nxt = (wdata == C_LEAVE) ? ST_READ : ST_BYP;
            ST_BUSY_P: if (op_done) nxt = prog_fail ? ST_ERR : (byp_q ? ST_BYP : ST_READ);
            ST_BUSY_E: begin
                if (op_done)                                 nxt = ST_READ;
                else if (wr_en && wdata == C_PAUSE && blk_q) nxt = ST_SUSP;
            end
            ST_SUSP: if (wr_en && wdata == C_BLOCK) nxt = ST_BUSY_E;
            ST_ERR:  if (wr_en && wdata == C_RESET) nxt = ST_READ;
            default: nxt = ST_READ;
        endcase
    end

    // State, return-to-fast-program flag and erase-kind registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_READ;
            byp_q <= 1'b0;
            blk_q <= 1'b0;
        end else begin
            st    <= nxt;
            byp_q <= byp_d;
            if (op_go) blk_q <= (op_kind == OP_BLK_ERASE);
        end
    end

endmodule

// File: rtl/norcmd_timer.sv
// Busy countdown standing in for program and erase time.
// Assumes len >= 1; hold freezes the count (erase suspend).
module norcmd_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [CNT_W-1:0] len,
    input  logic             hold,
    output logic             done,
    output logic             busy
);
    logic [CNT_W-1:0] cnt;

    assign busy = (cnt != '0);
    assign done = (cnt == CNT_W'(1)) && !hold;

    // Load on launch, count down while not held.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt <= '0;
        else if (go)                  cnt <= len;
        else if (busy && !hold)       cnt <= cnt - CNT_W'(1);
    end

endmodule

// File: rtl/norcmd_store.sv
// Byte array with bit-clearing program and block/chip erase.
// Assumes DEPTH and BLOCK_SIZE are powers of two; ops commit on commit pulse.
module norcmd_store
    import norcmd_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int BLOCK_SIZE = 16,
    localparam int IDX_W     = $clog2(DEPTH),
    localparam int OFS_W     = $clog2(BLOCK_SIZE),
    localparam int BLK_W     = IDX_W - OFS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  op_kind_e         kind,
    input  logic [IDX_W-1:0] op_idx,
    input  logic [7:0]       op_data,
    input  logic             commit,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    output logic             pend_bit7,
    output logic [BLK_W-1:0] pend_blk,
    output logic             fail_q
);
    logic [7:0]       mem [DEPTH];
    logic [IDX_W-1:0] p_idx;
    logic [7:0]       p_data;
    op_kind_e         p_kind;

    assign rd_data   = mem[rd_idx];
    assign pend_bit7 = p_data[7];
    assign pend_blk  = p_idx[IDX_W-1:OFS_W];

    // Latch the pending operation and detect 0-to-1 program attempts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_idx  <= '0;
            p_data <= '1;
            p_kind <= OP_NONE;
            fail_q <= 1'b0;
        end else if (go) begin
            p_idx  <= op_idx;
            p_data <= op_data;
            p_kind <= kind;
            fail_q <= (kind == OP_PROG) && ((op_data & ~mem[op_idx]) != 8'h00);
        end
    end

    // Apply the pending operation to the array when its countdown ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (commit) begin
            case (p_kind)
                OP_PROG: mem[p_idx] <= mem[p_idx] & p_data;
                OP_BLK_ERASE:
                    for (int i = 0; i < DEPTH; i++)
                        if ((i / BLOCK_SIZE) == int'(pend_blk)) mem[i] <= 8'hFF;
                OP_CHIP_ERASE:
                    for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/norcmd_emu.sv
// Top: NOR flash command interface emulator over a small byte array.
// Assumes rd_en and wr_en are never high in the same cycle; reads are registered.
module norcmd_emu
    import norcmd_pkg::*;
#(
    parameter int         ADDR_W     = 12,
    parameter int         DEPTH      = 64,
    parameter int         BLOCK_SIZE = 16,
    parameter int         PROG_CLKS  = 8,
    parameter int         ERASE_CLKS = 24,
    parameter logic [7:0] DEV_CODE   = 8'hEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              rd_vld,
    output logic              rdy
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int OFS_W = $clog2(BLOCK_SIZE);
    localparam int BLK_W = IDX_W - OFS_W;
    localparam int MAXC  = (PROG_CLKS > ERASE_CLKS) ? PROG_CLKS : ERASE_CLKS;
    localparam int CNT_W = $clog2(MAXC + 1);

    cmd_state_e       st;
    op_kind_e         op_kind;
    logic             op_go, op_done, pause, tmr_busy;
    logic             fail_q, pend_bit7, tog;
    logic [BLK_W-1:0] pend_blk;
    logic [7:0]       arr_data, rd_mux;
    logic             stat_rd;
    logic [CNT_W-1:0] len;

    assign len = (op_kind == OP_PROG) ? CNT_W'(PROG_CLKS) : CNT_W'(ERASE_CLKS);
    assign rdy = !(st == ST_BUSY_P || st == ST_BUSY_E);

    norcmd_decoder #(.ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .op_done(op_done), .prog_fail(fail_q), .st(st), .op_go(op_go),
        .op_kind(op_kind), .pause(pause)
    );

    norcmd_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .go(op_go), .len(len), .hold(pause),
        .done(op_done), .busy(tmr_busy)
    );

    norcmd_store #(.DEPTH(DEPTH), .BLOCK_SIZE(BLOCK_SIZE)) u_mem (
        .clk(clk), .rst_n(rst_n), .go(op_go), .kind(op_kind),
        .op_idx(addr[IDX_W-1:0]), .op_data(wdata), .commit(op_done),
        .rd_idx(addr[IDX_W-1:0]), .rd_data(arr_data),
        .pend_bit7(pend_bit7), .pend_blk(pend_blk), .fail_q(fail_q)
    );

    // Select what a read returns in the current mode.
    always_comb begin
        stat_rd = 1'b0;
        rd_mux  = arr_data;
        case (st)
            ST_AUTO: begin
                if (addr[7:0] == 8'h00)      rd_mux = 8'h20;
                else if (addr[7:0] == 8'h02) rd_mux = DEV_CODE;
                else                         rd_mux = 8'h00;
            end
            ST_CFI: begin
                case (addr[7:0])
                    8'h20:   rd_mux = 8'h51;
                    8'h22:   rd_mux = 8'h52;
                    8'h24:   rd_mux = 8'h59;
                    default: rd_mux = 8'h00;
                endcase
            end
            ST_BUSY_P: begin
                stat_rd = 1'b1;
                rd_mux  = {~pend_bit7, tog, fail_q, 5'b0};
            end
            ST_BUSY_E: begin
                stat_rd = 1'b1;
                rd_mux  = {1'b0, tog, 6'b0};
            end
            ST_ERR: begin
                stat_rd = 1'b1;
                rd_mux  = {~pend_bit7, tog, 1'b1, 5'b0};
            end
            ST_SUSP:
                if (addr[IDX_W-1:OFS_W] == pend_blk) rd_mux = {1'b1, tog, 6'b0};
            default: ;
        endcase
    end

    // Register read data, its valid flag and the toggle bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rd_vld <= 1'b0;
            tog    <= 1'b0;
        end else begin
            rd_vld <= rd_en;
            if (rd_en) rdata <= rd_mux;
            if (rd_en && stat_rd) tog <= ~tog;
        end
    end

endmodule

// File: rtl/norcmd_emu_sva.sv
// Checker for norcmd_emu, attached with bind; observes ports and mode state.
module norcmd_emu_sva
    import norcmd_pkg::*;
#(
    parameter int PROG_CLKS  = 8,
    parameter int ERASE_CLKS = 24
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wdata,
    input logic       rd_en,
    input logic       rd_vld,
    input logic [7:0] rdata,
    input logic       rdy,
    input cmd_state_e st
);
    localparam int MAXC = (PROG_CLKS > ERASE_CLKS) ? PROG_CLKS : ERASE_CLKS;
    int low_run;

    // Count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || rdy) low_run <= 0;
        else               low_run <= low_run + 1;
    end

    assert_rvld_R13: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_vld);
    assert_no_rvld_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_vld);
    assert_busy_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy |-> (low_run < MAXC));
    assert_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && st == ST_BUSY_P) ##1 (rd_en && st == ST_BUSY_P) |=> (rdata[6] != $past(rdata[6])));
    assert_erase_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && st == ST_BUSY_E) |=> (!rdata[7] && !rdata[5]));
    assert_susp_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SUSP) |-> rdy);
    assert_error_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERR && !(wr_en && wdata == C_RESET)) |=> (st == ST_ERR));

endmodule

bind norcmd_emu norcmd_emu_sva #(.PROG_CLKS(PROG_CLKS), .ERASE_CLKS(ERASE_CLKS)) u_sva (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en),
    .rd_vld(rd_vld), .rdata(rdata), .rdy(rdy), .st(st)
);

// File: tb/norcmd_emu_test.sv
// Scoreboard bench: read tasks queue expected bytes, a monitor compares them.
module norcmd_emu_test;
    localparam int PCLK = 6;
    localparam int ECLK = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        rd_vld, rdy;

    int    n_cmp = 0, n_bad = 0;
    bit    btog = 1'b0;
    bit    finished = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    norcmd_emu #(.ADDR_W(12), .DEPTH(64), .BLOCK_SIZE(16), .PROG_CLKS(PCLK),
                 .ERASE_CLKS(ECLK), .DEV_CODE(8'hEF)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rd_vld(rd_vld), .rdy(rdy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bw(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic unl();
        bw(12'hAAA, 8'hAA); bw(12'h555, 8'h55);
    endtask

    task automatic rd(input logic [11:0] a, input logic [7:0] e, input string tag);
        @(negedge clk); rd_en = 1'b1; addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk); rd_en = 1'b0;
    endtask

    // Status read that inverts DQ6 afterwards.
    task automatic rd_stat(input logic [11:0] a, input logic [7:0] base, input string tag);
        rd(a, base | {1'b0, btog, 6'b0}, tag);
        btog = ~btog;
    endtask

    task automatic wait_rdy();
        while (!rdy) @(negedge clk);
    endtask

    task automatic count_busy(input int exp, input string tag);
        int n = 0;
        while (!rdy) begin n++; @(negedge clk); end
        chk(tag, n, exp);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Monitor: compare each read result with the next queued expectation.
    always @(negedge clk) begin
        if (rd_vld) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R13 unexpected rd_vld actual=%0h expected=none", rdata);
            end else begin
                chk(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rdy after reset", rdy, 1);
        chk("R13 no rd_vld idle", rd_vld, 0);
        rd(12'h000, 8'hFF, "R1 erased byte 0");
        rd(12'h03F, 8'hFF, "R1 erased byte 63");

        // Program 5Ch, two status reads while busy.
        unl(); bw(12'hAAA, 8'hA0); bw(12'h003, 8'h5C);
        chk("R8 rdy low on program", rdy, 0);
        rd_stat(12'h003, 8'h80, "R7 status 1");
        rd_stat(12'h003, 8'h80, "R7 status 2");
        wait_rdy();
        rd(12'h003, 8'h5C, "R2 programmed byte");
        rd(12'h003, 8'h5C, "R7 no toggle after done");

        // 0->1 attempt: error status until reset command.
        unl(); bw(12'hAAA, 8'hA0); bw(12'h003, 8'hFF);
        wait_rdy();
        rd_stat(12'h003, 8'h20, "R3 error status 1");
        rd_stat(12'h010, 8'h20, "R3 error status 2");
        bw(12'h000, 8'hF0);
        rd(12'h003, 8'h5C, "R3 bits stay 0");

        // Broken unlock (wrong address on second cycle).
        bw(12'hAAA, 8'hAA); bw(12'h123, 8'h55); bw(12'hAAA, 8'hA0); bw(12'h005, 8'h00);
        chk("R4 no busy after broken unlock", rdy, 1);
        rd(12'h005, 8'hFF, "R4 no program");

        // Identification then query.
        unl(); bw(12'hAAA, 8'h90);
        rd(12'h000, 8'h20, "R5 maker code");
        rd(12'h002, 8'hEF, "R5 device code");
        rd(12'h004, 8'h00, "R5 other ident");
        bw(12'h0AA, 8'h98);
        rd(12'h020, 8'h51, "R6 query Q");
        rd(12'h022, 8'h52, "R6 query R");
        rd(12'h024, 8'h59, "R6 query Y");
        rd(12'h026, 8'h00, "R6 query other");
        bw(12'h000, 8'hF0);
        rd(12'h003, 8'h5C, "R5 back to reading");
        bw(12'h0AA, 8'h98);
        rd(12'h022, 8'h52, "R6 query from reading");
        bw(12'h000, 8'hF0);

        // Fast-program mode.
        unl(); bw(12'hAAA, 8'h20);
        bw(12'h0AA, 8'h98);
        rd(12'h003, 8'h5C, "R6 query ignored in fast mode");
        bw(12'h000, 8'hA0); bw(12'h010, 8'h0F); wait_rdy();
        rd(12'h010, 8'h0F, "R9 fast program 1");
        bw(12'h000, 8'hA0); bw(12'h011, 8'h07); wait_rdy();
        rd(12'h011, 8'h07, "R9 fast program 2");
        bw(12'h000, 8'h90); bw(12'h000, 8'h00);
        bw(12'hAAA, 8'hA0); bw(12'h012, 8'h00);
        chk("R9 left fast mode", rdy, 1);
        rd(12'h012, 8'hFF, "R9 no program after exit");

        // Block erase of block 0 with suspend/resume.
        unl(); bw(12'hAAA, 8'h80); unl(); bw(12'h000, 8'h30);
        rd_stat(12'h003, 8'h00, "R10 erase status");
        bw(12'h000, 8'hB0);
        chk("R12 rdy high in suspend", rdy, 1);
        rd(12'h003, 8'h80 | {1'b0, btog, 6'b0}, "R12 erasing block read");
        rd(12'h010, 8'h0F, "R12 other block read");
        rd(12'h004, 8'h80 | {1'b0, btog, 6'b0}, "R12 DQ6 held");
        bw(12'h000, 8'h30);
        chk("R12 resumed busy", rdy, 0);
        wait_rdy();
        rd(12'h003, 8'hFF, "R10 block erased");
        rd(12'h00F, 8'hFF, "R10 block end erased");
        rd(12'h010, 8'h0F, "R10 neighbour kept");

        // Exact busy windows.
        unl(); bw(12'hAAA, 8'hA0); bw(12'h020, 8'h33);
        count_busy(PCLK - 0, "R8 program cycles");
        rd(12'h020, 8'h33, "R2 program after count");
        unl(); bw(12'hAAA, 8'h80); unl(); bw(12'hAAA, 8'h10);
        count_busy(ECLK, "R8 erase cycles");
        rd(12'h010, 8'hFF, "R11 chip erase a");
        rd(12'h011, 8'hFF, "R11 chip erase b");
        rd(12'h020, 8'hFF, "R11 chip erase c");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) chk("R13 pending reads", exp_q.size(), 0);
        summary();
    end

endmodule